// File: doc/BRIEF.md
# DMA Transfer Counter and Length Selector

This block keeps the 16-bit byte counter used by the data path of a parallel-bus storage controller. Software writes a start count as two bytes. Any command issued in DMA mode copies that start count into a live counter. When a transfer-information operation starts, the block works out how many bytes that operation will move. The number comes from the live count, from a signed figure for the bytes still owed by the current bus phase, and from whether a command block is being captured.

While the operation runs, each byte moved decrements the live count. When the bytes moved reach the selected length, the block raises a one-cycle completion pulse. At the same point it sets the terminal-count and interrupt status bits, flags a bus-service interrupt cause, and forces the live count to read zero. Neighbouring logic uses the completion pulse to clear its sequence-step and FIFO-flag registers. The block does not move memory itself.

Top module: `xfer_count_top`

## Requirements
- R1: After reset, both count bytes read 0, and `xfer_busy`, `done`, `stat_tc`, `stat_int` and `intr_bus_svc` are all 0.
- R2: A write to a count byte changes only the programmed start count. The live count (`count_hi`:`count_lo`) takes the programmed value on the clock after `cmd_stb` with `cmd_dma`=1. A `cmd_stb` with `cmd_dma`=0 leaves the live count unchanged.
- R3: A write to either count byte clears `stat_tc` on the next clock.
- R4: A live count of zero at the start of an operation counts as 65536 bytes.
- R5: While `cmd_capture`=1, the selected length is min(count, 32) and `xfer_to_dev` is 1.
- R6: With no capture and a negative `remain_size`, `xfer_to_dev` is 1 and the length is min(count, |remain_size|).
- R7: With no capture and a `remain_size` of zero or more, `xfer_to_dev` is 0 and the length is min(count, remain_size). A length of 0 completes at once: `done` is high in the first cycle after the start.
- R8: An accepted `xfer_start` sets `xfer_busy`, shows the selected length on `xfer_len`, and clears `stat_tc`.
- R9: Each `byte_moved` accepted while busy lowers the live count by one. `done` is high for exactly one cycle, in the cycle after the accepted byte count reaches `xfer_len`.
- R10: On the clock that ends `done`: `stat_tc`=1, `stat_int`=1, `intr_bus_svc`=1, both count bytes read 0, and `xfer_busy`=0.
- R11: `int_ack` clears `stat_int` and `intr_bus_svc` but leaves `stat_tc` unchanged.
- R12: An `xfer_start` that arrives while busy is ignored. `xfer_len` and the progress of the running operation are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_wr_lo | input | 1 | Write low byte of start count |
| cnt_wr_hi | input | 1 | Write high byte of start count |
| cnt_wr_data | input | 8 | Count byte write data |
| cmd_stb | input | 1 | A command is being issued |
| cmd_dma | input | 1 | DMA-mode bit of the issued command |
| xfer_start | input | 1 | Start a transfer-information operation |
| remain_size | input | 32 | Signed bytes still owed by the phase; negative means toward the device |
| cmd_capture | input | 1 | A command block is being captured |
| byte_moved | input | 1 | One byte moved this cycle |
| int_ack | input | 1 | Interrupt cause has been read |
| count_lo | output | 8 | Live count, low byte |
| count_hi | output | 8 | Live count, high byte |
| xfer_len | output | 17 | Length selected for the running operation |
| xfer_to_dev | output | 1 | Direction of the running operation, 1 = toward the device |
| xfer_busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| stat_tc | output | 1 | Terminal-count status bit |
| stat_int | output | 1 | Interrupt-pending status bit |
| intr_bus_svc | output | 1 | Bus-service interrupt cause |

## Verification
The case that is hardest to reach from the ports is the zero count that stands for 65536. To see it, the programmed count must be zero, a DMA command must reload it, and the remaining size must be larger than 65536. Otherwise the clip hides the difference between 0 and 65536. The bench sets up exactly that and reads the selected length. It also drives a zero remaining size to show that an operation can complete with no bytes. A second start is sent into a running operation to show it has no effect on the length or on the count of bytes still to move.

// File: rtl/xfer_count_pkg.sv
// Shared types and helpers for the transfer counter.
// Assumes a count of exactly two bytes.
package xfer_count_pkg;
    typedef enum logic {
        DIR_FROM_DEV = 1'b0,
        DIR_TO_DEV   = 1'b1
    } xfer_dir_t;
endpackage

// File: rtl/xfer_count_regs.sv
// Holds the programmed start count and the live count.
// Assumes CNT_W is even: the count is written as a low half and a high half.
// Priority on the live count: clear, then reload, then decrement.
module xfer_count_regs #(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic [CNT_W/2-1:0]    wr_data,
    input  logic                  reload,
    input  logic                  dec,
    input  logic                  clear_live,
    output logic [CNT_W-1:0]      live
);
    localparam int HALF_W = CNT_W / 2;

    logic [CNT_W-1:0] prog_q;
    logic [CNT_W-1:0] live_q;

    // Store the programmed start count, one half per write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_q <= '0;
        end else begin
            if (wr_lo) prog_q[HALF_W-1:0]     <= wr_data;
            if (wr_hi) prog_q[CNT_W-1:HALF_W] <= wr_data;
        end
    end

    // Update the live count: cleared on completion, reloaded by a DMA command, else decremented per byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
        end else if (clear_live) begin
            live_q <= '0;
        end else if (reload) begin
            live_q <= prog_q;
        end else if (dec) begin
            live_q <= live_q - 1'b1;
        end
    end

    assign live = live_q;

    // R2: a DMA command copies the programmed value.
    a_r2_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !clear_live) |=> (live_q == $past(prog_q)));

    // R9: each accepted byte lowers the live count by one.
    a_r9_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !reload && !clear_live) |=> (live_q == $past(live_q) - 1'b1));

    // R10: the count reads zero after completion.
    a_r10_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        clear_live |=> (live_q == '0));
endmodule

// File: rtl/xfer_len_sel.sv
// Combinational choice of the operation length and direction.
// A zero count stands for 2**CNT_W bytes.
// Assumes SIZE_W > CNT_W + 1 so that every compare fits in SIZE_W.
module xfer_len_sel
    import xfer_count_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int SIZE_W  = 32,
    parameter int CAP_LEN = 32
) (
    input  logic [CNT_W-1:0]    live,
    input  logic [SIZE_W-1:0]   remain,
    input  logic                capture,
    output logic [CNT_W:0]      sel_len,
    output xfer_dir_t           sel_dir
);
    localparam int LEN_W = CNT_W + 1;

    logic [LEN_W-1:0]  cnt_eff;
    logic [SIZE_W-1:0] cnt_wide;
    logic [SIZE_W-1:0] mag;
    logic [SIZE_W-1:0] limit;

    // Expand the count, turning zero into the full span.
    always_comb begin
        cnt_eff  = (live == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, live};
        cnt_wide = SIZE_W'(cnt_eff);
    end

    // Find the magnitude of the signed remaining size.
    always_comb begin
        mag = remain[SIZE_W-1] ? (~remain + 1'b1) : remain;
    end

    // Pick the clip limit and take the smaller of it and the count.
    always_comb begin
        limit   = capture ? SIZE_W'(CAP_LEN) : mag;
        sel_len = (cnt_wide <= limit) ? cnt_eff : LEN_W'(limit);
        sel_dir = (capture || remain[SIZE_W-1]) ? DIR_TO_DEV : DIR_FROM_DEV;
    end
endmodule

// File: rtl/xfer_track.sv
// Runs one transfer-information operation.
// It latches the selected length and direction, counts the bytes accepted,
// raises the one-cycle completion pulse and keeps the status bits.
// Assumes byte_moved is only meaningful while busy.
module xfer_track
    import xfer_count_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               byte_moved,
    input  logic               cnt_wr,
    input  logic               int_ack,
    input  logic [CNT_W:0]     sel_len,
    input  xfer_dir_t          sel_dir,
    output logic               busy,
    output logic [CNT_W:0]     len_q,
    output xfer_dir_t          dir_q,
    output logic               accept,
    output logic               done,
    output logic               tc,
    output logic               int_pend,
    output logic               bus_svc
);
    localparam int LEN_W = CNT_W + 1;

    logic [LEN_W-1:0] moved_q;
    logic             take;

    assign take   = start && !busy;
    assign done   = busy && (moved_q == len_q);
    assign accept = busy && byte_moved && (moved_q != len_q);

    // Sequence the operation: latch on start, count bytes, finish on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            len_q   <= '0;
            dir_q   <= DIR_FROM_DEV;
            moved_q <= '0;
        end else if (done) begin
            busy <= 1'b0;
        end else if (take) begin
            busy    <= 1'b1;
            len_q   <= sel_len;
            dir_q   <= sel_dir;
            moved_q <= '0;
        end else if (accept) begin
            moved_q <= moved_q + 1'b1;
        end
    end

    // Keep terminal count: set on completion, cleared by a count write or a start.
    always_ff @(posedge clk) begin
        if (!rst_n)                tc <= 1'b0;
        else if (done)             tc <= 1'b1;
        else if (cnt_wr || take)   tc <= 1'b0;
    end

    // Keep the interrupt flag and its bus-service cause until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_pend <= 1'b0;
            bus_svc  <= 1'b0;
        end else if (done) begin
            int_pend <= 1'b1;
            bus_svc  <= 1'b1;
        end else if (int_ack) begin
            int_pend <= 1'b0;
            bus_svc  <= 1'b0;
        end
    end

    // R9: the completion pulse lasts one cycle.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: the byte count never passes the selected length.
    a_r9_moved_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (moved_q <= len_q));

    // R10: completion raises both status bits and ends the operation.
    a_r10_status: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (tc && int_pend && bus_svc && !busy));

    // R3: a count write clears terminal count.
    a_r3_wr_clears_tc: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && !done) |=> !tc);

    // R8: an accepted start clears terminal count and sets busy.
    a_r8_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !tc));

    // R11: an acknowledge drops the interrupt but keeps terminal count.
    a_r11_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !done && !cnt_wr && !(start && !busy)) |=> (!int_pend && !bus_svc && $stable(tc)));

    // R12: a start during a running operation leaves the length alone.
    a_r12_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && !done) |=> (busy && $stable(len_q)));
endmodule

// File: rtl/xfer_count_top.sv
// Top of the transfer counter.
// It joins the count registers, the length selector and the operation tracker.
// A DMA command reloads the live count; completion clears it.
module xfer_count_top
    import xfer_count_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int SIZE_W  = 32,
    parameter int CAP_LEN = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cnt_wr_lo,
    input  logic                 cnt_wr_hi,
    input  logic [CNT_W/2-1:0]   cnt_wr_data,
    input  logic                 cmd_stb,
    input  logic                 cmd_dma,
    input  logic                 xfer_start,
    input  logic [SIZE_W-1:0]    remain_size,
    input  logic                 cmd_capture,
    input  logic                 byte_moved,
    input  logic                 int_ack,
    output logic [CNT_W/2-1:0]   count_lo,
    output logic [CNT_W/2-1:0]   count_hi,
    output logic [CNT_W:0]       xfer_len,
    output logic                 xfer_to_dev,
    output logic                 xfer_busy,
    output logic                 done,
    output logic                 stat_tc,
    output logic                 stat_int,
    output logic                 intr_bus_svc
);
    localparam int HALF_W = CNT_W / 2;

    logic [CNT_W-1:0] live;
    logic [CNT_W:0]   sel_len;
    xfer_dir_t        sel_dir;
    xfer_dir_t        dir_q;
    logic             accept;
    logic             reload;
    logic             cnt_wr;

    assign reload = cmd_stb && cmd_dma;
    assign cnt_wr = cnt_wr_lo || cnt_wr_hi;

    xfer_count_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_lo      (cnt_wr_lo),
        .wr_hi      (cnt_wr_hi),
        .wr_data    (cnt_wr_data),
        .reload     (reload),
        .dec        (accept),
        .clear_live (done),
        .live       (live)
    );

    xfer_len_sel #(.CNT_W(CNT_W), .SIZE_W(SIZE_W), .CAP_LEN(CAP_LEN)) u_sel (
        .live    (live),
        .remain  (remain_size),
        .capture (cmd_capture),
        .sel_len (sel_len),
        .sel_dir (sel_dir)
    );

    xfer_track #(.CNT_W(CNT_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (xfer_start),
        .byte_moved (byte_moved),
        .cnt_wr     (cnt_wr),
        .int_ack    (int_ack),
        .sel_len    (sel_len),
        .sel_dir    (sel_dir),
        .busy       (xfer_busy),
        .len_q      (xfer_len),
        .dir_q      (dir_q),
        .accept     (accept),
        .done       (done),
        .tc         (stat_tc),
        .int_pend   (stat_int),
        .bus_svc    (intr_bus_svc)
    );

    assign count_lo    = live[HALF_W-1:0];
    assign count_hi    = live[CNT_W-1:HALF_W];
    assign xfer_to_dev = (dir_q == DIR_TO_DEV);

    // R5: during capture, an accepted start is capped and runs toward the device.
    a_r5_capture_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && !xfer_busy && cmd_capture) |=> ((xfer_len <= CAP_LEN) && xfer_to_dev));
endmodule

// File: tb/tb_xfer_count_top.sv
// Directed bench for the transfer counter: one task per scenario.
module tb_xfer_count_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cnt_wr_lo, cnt_wr_hi;
    logic [7:0]  cnt_wr_data;
    logic        cmd_stb, cmd_dma, xfer_start;
    logic [31:0] remain_size;
    logic        cmd_capture, byte_moved, int_ack;
    logic [7:0]  count_lo, count_hi;
    logic [16:0] xfer_len;
    logic        xfer_to_dev, xfer_busy, done, stat_tc, stat_int, intr_bus_svc;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    xfer_count_top dut (
        .clk(clk), .rst_n(rst_n), .cnt_wr_lo(cnt_wr_lo), .cnt_wr_hi(cnt_wr_hi),
        .cnt_wr_data(cnt_wr_data), .cmd_stb(cmd_stb), .cmd_dma(cmd_dma),
        .xfer_start(xfer_start), .remain_size(remain_size), .cmd_capture(cmd_capture),
        .byte_moved(byte_moved), .int_ack(int_ack), .count_lo(count_lo),
        .count_hi(count_hi), .xfer_len(xfer_len), .xfer_to_dev(xfer_to_dev),
        .xfer_busy(xfer_busy), .done(done), .stat_tc(stat_tc), .stat_int(stat_int),
        .intr_bus_svc(intr_bus_svc)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] count16();
        return {16'd0, count_hi, count_lo};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; cnt_wr_lo = 0; cnt_wr_hi = 0; cnt_wr_data = 0;
        cmd_stb = 0; cmd_dma = 0; xfer_start = 0; remain_size = 0;
        cmd_capture = 0; byte_moved = 0; int_ack = 0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic write_count(input logic [15:0] v);
        cnt_wr_lo = 1; cnt_wr_data = v[7:0]; tick();
        cnt_wr_lo = 0; cnt_wr_hi = 1; cnt_wr_data = v[15:8]; tick();
        cnt_wr_hi = 0;
    endtask

    task automatic issue_cmd(input logic dma);
        cmd_stb = 1; cmd_dma = dma; tick();
        cmd_stb = 0; cmd_dma = 0;
    endtask

    task automatic start_op(input logic [31:0] rem, input logic cap);
        remain_size = rem; cmd_capture = cap; xfer_start = 1; tick();
        xfer_start = 0;
    endtask

    task automatic move_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            byte_moved = 1; tick();
        end
        byte_moved = 0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 count", count16(), 0);
        check("R1 busy", xfer_busy, 0);
        check("R1 done", done, 0);
        check("R1 status", {stat_tc, stat_int, intr_bus_svc}, 0);
    endtask

    task automatic t_reload();
        do_reset();
        write_count(16'h0105);
        check("R2 write alone", count16(), 0);
        issue_cmd(1'b0);
        check("R2 non-DMA command", count16(), 0);
        issue_cmd(1'b1);
        check("R2 DMA reload", count16(), 32'h0105);
    endtask

    task automatic t_positive();
        // count 261, remaining 10 from the device
        start_op(32'd10, 1'b0);
        check("R7 length", xfer_len, 10);
        check("R7 direction", xfer_to_dev, 0);
        check("R8 busy", xfer_busy, 1);
        move_bytes(3);
        check("R9 decrement", count16(), 258);
        check("R9 no early done", done, 0);
        move_bytes(7);
        check("R9 done pulse", done, 1);
        check("R9 count before clear", count16(), 251);
        tick();
        check("R9 pulse ends", done, 0);
        check("R10 status", {stat_tc, stat_int, intr_bus_svc}, 3'b111);
        check("R10 count zero", count16(), 0);
        check("R10 idle", xfer_busy, 0);
    endtask

    task automatic t_ack();
        int_ack = 1; tick(); int_ack = 0;
        check("R11 int cleared", {stat_int, intr_bus_svc}, 0);
        check("R11 tc kept", stat_tc, 1);
    endtask

    task automatic t_negative();
        write_count(16'd20);
        issue_cmd(1'b1);
        start_op(-32'sd5, 1'b0);
        check("R6 length small", xfer_len, 5);
        check("R6 direction", xfer_to_dev, 1);
        check("R8 tc cleared by start", stat_tc, 0);
        move_bytes(5);
        check("R9 done", done, 1);
        tick();
        issue_cmd(1'b1);
        start_op(-32'sd100, 1'b0);
        check("R6 length by count", xfer_len, 20);
        move_bytes(20);
        tick();
        check("R10 tc set", stat_tc, 1);
    endtask

    task automatic t_tc_write();
        cnt_wr_lo = 1; cnt_wr_data = 8'h07; tick(); cnt_wr_lo = 0;
        check("R3 tc cleared", stat_tc, 0);
    endtask

    task automatic t_capture();
        do_reset();
        write_count(16'd100);
        issue_cmd(1'b1);
        start_op(32'd5000, 1'b1);
        check("R5 capped length", xfer_len, 32);
        check("R5 direction", xfer_to_dev, 1);
        do_reset();
        write_count(16'd8);
        issue_cmd(1'b1);
        start_op(-32'sd3, 1'b1);
        check("R5 count below cap", xfer_len, 8);
    endtask

    task automatic t_zero_count();
        do_reset();
        write_count(16'd0);
        issue_cmd(1'b1);
        start_op(32'd65537, 1'b0);
        check("R4 zero means 65536", xfer_len, 32'h10000);
        do_reset();
        start_op(32'd300, 1'b0);
        check("R4 zero clipped", xfer_len, 300);
    endtask

    task automatic t_zero_len();
        do_reset();
        write_count(16'd5);
        issue_cmd(1'b1);
        start_op(32'd0, 1'b0);
        check("R7 zero length", xfer_len, 0);
        check("R7 immediate done", done, 1);
        tick();
        check("R10 tc after empty op", stat_tc, 1);
    endtask

    task automatic t_busy_start();
        do_reset();
        write_count(16'd50);
        issue_cmd(1'b1);
        start_op(32'd10, 1'b0);
        move_bytes(4);
        start_op(32'd3, 1'b0);
        check("R12 length held", xfer_len, 10);
        check("R12 still busy", xfer_busy, 1);
        move_bytes(5);
        check("R12 no early done", done, 0);
        move_bytes(1);
        check("R12 done at full length", done, 1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        t_reset();
        t_reload();
        t_positive();
        t_ack();
        t_negative();
        t_tc_write();
        t_capture();
        t_zero_count();
        t_zero_len();
        t_busy_start();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule